// File: doc/BRIEF.md
# Flow-Controlled Master Strobe Generator

This block runs the data phase of a transfer in which the interface is the bus master. Two condition terms are each picked from six ready inputs, a FIFO flag and a processor-driven ready bit. A selectable two-input logic function combines them into one flow result. While the flow state is active, that result decides whether a chosen control pin, the strobe, toggles at a programmed rate or holds its level. Every enabled strobe edge raises a one-cycle transfer pulse toward the FIFO side. The remaining control pins take one of two 6-bit patterns, selected by the flow result.

A sequencer outside this block starts the flow state with a one-cycle start pulse. It asks the block to leave by holding a done request. The block accepts that request only on a half-period boundary, so the last strobe phase always runs to full length. After the exit, the control pins return to the per-state pattern that the sequencer supplies. In sustain mode the strobe keeps its final level until the per-state strobe bit goes to 1. That forces the strobe high and gives control back to the per-state pattern.

The strobe half-period is counted in half clock periods. A phase accumulator adds two half-periods on each clock, so the average rate is exact and each edge falls on a clock edge. An optional synchronizer chain on the ready inputs can be enabled by a parameter.

Top module: `flow_strobe_gen`

## Requirements
- R1: While rst is high, ctl_out, xfer_pulse and flow_exit are all 0. Outside the flow state, and with no sustain hold, ctl_out equals state_ctl one clock after it is applied.
- R2: Each term select code picks one term: codes 0 to 5 pick rdy_in[0] to rdy_in[5], code 6 picks fifo_flag, and code 7 picks cpu_rdy.
- R3: logic_fn selects the flow result: 00 = A AND B, 01 = A OR B, 10 = A XOR B, 11 = (NOT A) AND B.
- R4: In the flow state the strobe may change only when the flow result equals toggle_when. For the other result it keeps its level.
- R5: half_per gives the strobe half-period in half clock periods, and values below 2 act as 2. After entry, boundaries fall where the running sum of 2 per clock reaches half_per: every clock for 2, at the 3rd and 6th clock for 6, and twice in every three clocks for 3. The strobe toggles only on a boundary.
- R6: xfer_pulse is high for one clock, in the same cycle that ctl_out shows a strobe rise (when xfer_on_rise is 1) or a strobe fall (when xfer_on_fall is 1). It is never high outside the flow state.
- R7: After the flow result leaves the toggle value, the strobe makes at most one further edge.
- R8: In the flow state, every control pin other than the strobe shows ctl_when1 when the flow result is 1 and ctl_when0 when it is 0, one clock after the inputs.
- R9: strb_sel (0 to 5) names the control pin that carries the strobe. The flow patterns never drive that pin.
- R10: done_req is honoured only on a boundary. flow_exit is then high for exactly one clock, and the strobe does not toggle on that boundary.
- R11: With sustain_en set at exit, the strobe keeps its final level while the per-state strobe bit is 0. When that bit becomes 1 the strobe goes to 1, and from then on it follows state_ctl again.
- R12: With sustain_en clear at exit, the strobe follows the per-state strobe bit on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_start | input | 1 | One-cycle request to enter the flow state |
| done_req | input | 1 | Request to leave the flow state |
| rdy_in | input | 6 | Ready inputs, term codes 0-5 |
| fifo_flag | input | 1 | FIFO flag, term code 6 |
| cpu_rdy | input | 1 | Processor ready bit, term code 7 |
| term_a_sel | input | 3 | Source code for term A |
| term_b_sel | input | 3 | Source code for term B |
| logic_fn | input | 2 | Flow function code |
| toggle_when | input | 1 | Flow result value that lets the strobe toggle |
| half_per | input | 8 | Strobe half-period in half clock periods |
| xfer_on_rise | input | 1 | Transfer on a rising strobe edge |
| xfer_on_fall | input | 1 | Transfer on a falling strobe edge |
| strb_sel | input | 3 | Control pin that carries the strobe |
| ctl_when0 | input | 6 | Control pattern for flow result 0 |
| ctl_when1 | input | 6 | Control pattern for flow result 1 |
| sustain_en | input | 1 | Hold the strobe level after exit |
| state_ctl | input | 6 | Per-state control pattern used outside the flow state |
| ctl_out | output | 6 | Registered control pins |
| xfer_pulse | output | 1 | Data-transfer pulse to the FIFO side |
| flow_exit | output | 1 | One-cycle pulse when the flow state ends |

## Verification
An exit and a strobe toggle both want the same half-period boundary. The bench provokes this by raising done_req while the flow result still permits toggling, using a half-period of four clocks. It then checks that flow_exit rises exactly on the fourth clock after entry and not before, and that the strobe level on that clock is unchanged. Transfer pulses and strobe edges also share each cycle. They are judged together on every sampled clock by comparing xfer_pulse against the edge direction seen on ctl_out.

// File: rtl/flow_strobe_pkg.sv
package flow_strobe_pkg;

  localparam int TERM_W    = 3;
  localparam int TERM_FIFO = 6;
  localparam int TERM_CPU  = 7;

  typedef enum logic [1:0] {
    FN_AND      = 2'b00,
    FN_OR       = 2'b01,
    FN_XOR      = 2'b10,
    FN_NA_AND_B = 2'b11
  } flow_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FLOW = 2'd1,
    ST_HOLD = 2'd2
  } flow_st_e;

endpackage

// File: rtl/flow_term_logic.sv
module flow_term_logic
  import flow_strobe_pkg::*;
#(
  parameter int NRDY = 6
) (
  input  logic [NRDY-1:0]   rdy_s,
  input  logic              fifo_flag,
  input  logic              cpu_rdy,
  input  logic [TERM_W-1:0] sel_a,
  input  logic [TERM_W-1:0] sel_b,
  input  logic [1:0]        func,
  output logic              result
);

  localparam int NTERM = 1 << TERM_W;

  logic [NTERM-1:0] terms;
  logic             ta, tb;

  // ready inputs occupy the low codes; missing ones read as 0
  for (genvar k = 0; k < TERM_FIFO; k++) begin : g_term
    if (k < NRDY) begin : g_pin
      assign terms[k] = rdy_s[k];
    end else begin : g_zero
      assign terms[k] = 1'b0;
    end
  end
  assign terms[TERM_FIFO] = fifo_flag;
  assign terms[TERM_CPU]  = cpu_rdy;

  assign ta = terms[sel_a];
  assign tb = terms[sel_b];

  always_comb begin
    case (flow_fn_e'(func))
      FN_AND:      result = ta & tb;
      FN_OR:       result = ta | tb;
      FN_XOR:      result = ta ^ tb;
      FN_NA_AND_B: result = ~ta & tb;
      default:     result = 1'b0;
    endcase
  end

endmodule

// File: rtl/flow_halfper.sv
module flow_halfper #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HP_W-1:0] half_per,
  output logic            bnd
);

  localparam int ACC_W = HP_W + 1;

  logic [ACC_W-1:0] acc, sum, hp_eff;

  // values below one full clock are clamped to one full clock
  assign hp_eff = (half_per < HP_W'(2)) ? ACC_W'(2) : ACC_W'(half_per);
  assign sum    = acc + ACC_W'(2);
  assign bnd    = run && (sum >= hp_eff);

  always_ff @(posedge clk) begin
    if (rst || !run) acc <= '0;
    else if (bnd)    acc <= sum - hp_eff;
    else             acc <= sum;
  end

  // accumulator stays below the period once it has been there
  p_acc_below_r5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $stable(half_per) && ($past(acc) < $past(hp_eff)))
      |-> (acc < hp_eff));

endmodule

// File: rtl/flow_strobe_ctl.sv
module flow_strobe_ctl
  import flow_strobe_pkg::*;
#(
  parameter int NCTL = 6,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flow_start,
  input  logic            done_req,
  input  logic            result,
  input  logic            toggle_when,
  input  logic            bnd,
  input  logic            xfer_on_rise,
  input  logic            xfer_on_fall,
  input  logic [SELW-1:0] strb_sel,
  input  logic [NCTL-1:0] ctl_when0,
  input  logic [NCTL-1:0] ctl_when1,
  input  logic [NCTL-1:0] state_ctl,
  input  logic            sustain_en,
  output logic            in_flow,
  output logic [NCTL-1:0] ctl_out,
  output logic            xfer_pulse,
  output logic            flow_exit
);

  flow_st_e        st, st_n;
  logic            strb_q, strb_n;
  logic            exit_n, pulse_n;
  logic [NCTL-1:0] sel_oh, pat, ctl_n;
  logic            state_bit;

  for (genvar i = 0; i < NCTL; i++) begin : g_oh
    assign sel_oh[i] = (strb_sel == SELW'(i));
  end

  assign state_bit = |(state_ctl & sel_oh);
  assign pat       = result ? ctl_when1 : ctl_when0;
  assign in_flow   = (st == ST_FLOW);

  always_comb begin
    st_n   = st;
    strb_n = strb_q;
    exit_n = 1'b0;
    case (st)
      ST_IDLE: begin
        if (flow_start) st_n   = ST_FLOW;
        else            strb_n = state_bit;
      end
      ST_FLOW: begin
        if (bnd) begin
          if (done_req) begin
            exit_n = 1'b1;
            st_n   = sustain_en ? ST_HOLD : ST_IDLE;
          end else if (result == toggle_when) begin
            strb_n = ~strb_q;
          end
        end
      end
      ST_HOLD: begin
        if (flow_start) begin
          st_n = ST_FLOW;
        end else if (state_bit) begin
          strb_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign pulse_n = (st == ST_FLOW) &&
                   ((strb_n && !strb_q && xfer_on_rise) ||
                    (!strb_n && strb_q && xfer_on_fall));

  for (genvar i = 0; i < NCTL; i++) begin : g_pin
    assign ctl_n[i] = sel_oh[i] ? strb_n
                    : ((st_n == ST_FLOW) ? pat[i] : state_ctl[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      strb_q     <= 1'b0;
      ctl_out    <= '0;
      xfer_pulse <= 1'b0;
      flow_exit  <= 1'b0;
    end else begin
      st         <= st_n;
      strb_q     <= strb_n;
      ctl_out    <= ctl_n;
      xfer_pulse <= pulse_n;
      flow_exit  <= exit_n;
    end
  end

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLOW && result != toggle_when) |=> $stable(strb_q));

  p_hold_between_bnd_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLOW && !bnd) |=> $stable(strb_q));

  p_pulse_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |-> (strb_q != $past(strb_q)));

  p_pulse_only_flow_r6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_FLOW) |=> !xfer_pulse);

  p_exit_on_bnd_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLOW && !bnd) |=> !flow_exit);

  p_sustain_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !state_bit && !flow_start) |=> $stable(strb_q));

endmodule

// File: rtl/flow_strobe_gen.sv
module flow_strobe_gen
  import flow_strobe_pkg::*;
#(
  parameter int NCTL        = 6,
  parameter int NRDY        = 6,
  parameter int HP_W        = 8,
  parameter int SYNC_STAGES = 0,
  localparam int SELW       = $clog2(NCTL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_start,
  input  logic              done_req,
  input  logic [NRDY-1:0]   rdy_in,
  input  logic              fifo_flag,
  input  logic              cpu_rdy,
  input  logic [TERM_W-1:0] term_a_sel,
  input  logic [TERM_W-1:0] term_b_sel,
  input  logic [1:0]        logic_fn,
  input  logic              toggle_when,
  input  logic [HP_W-1:0]   half_per,
  input  logic              xfer_on_rise,
  input  logic              xfer_on_fall,
  input  logic [SELW-1:0]   strb_sel,
  input  logic [NCTL-1:0]   ctl_when0,
  input  logic [NCTL-1:0]   ctl_when1,
  input  logic              sustain_en,
  input  logic [NCTL-1:0]   state_ctl,
  output logic [NCTL-1:0]   ctl_out,
  output logic              xfer_pulse,
  output logic              flow_exit
);

  logic [NRDY-1:0] rdy_s;
  logic            result, bnd, in_flow;

  if (SYNC_STAGES == 0) begin : g_nosync
    assign rdy_s = rdy_in;
  end else begin : g_sync
    logic [NRDY-1:0] stage [SYNC_STAGES];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
      end else begin
        stage[0] <= rdy_in;
        for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      end
    end
    assign rdy_s = stage[SYNC_STAGES-1];
  end

  flow_term_logic #(.NRDY(NRDY)) u_term (
    .rdy_s     (rdy_s),
    .fifo_flag (fifo_flag),
    .cpu_rdy   (cpu_rdy),
    .sel_a     (term_a_sel),
    .sel_b     (term_b_sel),
    .func      (logic_fn),
    .result    (result)
  );

  flow_halfper #(.HP_W(HP_W)) u_hp (
    .clk      (clk),
    .rst      (rst),
    .run      (in_flow),
    .half_per (half_per),
    .bnd      (bnd)
  );

  flow_strobe_ctl #(.NCTL(NCTL), .SELW(SELW)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .flow_start   (flow_start),
    .done_req     (done_req),
    .result       (result),
    .toggle_when  (toggle_when),
    .bnd          (bnd),
    .xfer_on_rise (xfer_on_rise),
    .xfer_on_fall (xfer_on_fall),
    .strb_sel     (strb_sel),
    .ctl_when0    (ctl_when0),
    .ctl_when1    (ctl_when1),
    .state_ctl    (state_ctl),
    .sustain_en   (sustain_en),
    .in_flow      (in_flow),
    .ctl_out      (ctl_out),
    .xfer_pulse   (xfer_pulse),
    .flow_exit    (flow_exit)
  );

endmodule

// File: tb/flow_strobe_gen_test.sv
module flow_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst, flow_start, done_req, fifo_flag, cpu_rdy, toggle_when;
  logic       xfer_on_rise, xfer_on_fall, sustain_en;
  logic [5:0] rdy_in, ctl_when0, ctl_when1, state_ctl;
  logic [2:0] term_a_sel, term_b_sel, strb_sel;
  logic [1:0] logic_fn;
  logic [7:0] half_per;
  logic [5:0] ctl_out;
  logic       xfer_pulse, flow_exit;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flow_strobe_gen uut (
    .clk(clk), .rst(rst), .flow_start(flow_start), .done_req(done_req),
    .rdy_in(rdy_in), .fifo_flag(fifo_flag), .cpu_rdy(cpu_rdy),
    .term_a_sel(term_a_sel), .term_b_sel(term_b_sel), .logic_fn(logic_fn),
    .toggle_when(toggle_when), .half_per(half_per),
    .xfer_on_rise(xfer_on_rise), .xfer_on_fall(xfer_on_fall),
    .strb_sel(strb_sel), .ctl_when0(ctl_when0), .ctl_when1(ctl_when1),
    .sustain_en(sustain_en), .state_ctl(state_ctl),
    .ctl_out(ctl_out), .xfer_pulse(xfer_pulse), .flow_exit(flow_exit)
  );

  // {sel_a, sel_b, fn, rdy[5:0], fifo, cpu, expected result}
  localparam logic [16:0] VEC [16] = '{
    {3'd0, 3'd1, 2'd0, 6'b000011, 1'b0, 1'b0, 1'b1},
    {3'd0, 3'd1, 2'd0, 6'b000001, 1'b0, 1'b0, 1'b0},
    {3'd2, 3'd3, 2'd1, 6'b001000, 1'b0, 1'b0, 1'b1},
    {3'd2, 3'd3, 2'd1, 6'b000000, 1'b0, 1'b0, 1'b0},
    {3'd4, 3'd5, 2'd2, 6'b010000, 1'b0, 1'b0, 1'b1},
    {3'd4, 3'd5, 2'd2, 6'b110000, 1'b0, 1'b0, 1'b0},
    {3'd6, 3'd7, 2'd0, 6'b000000, 1'b1, 1'b1, 1'b1},
    {3'd6, 3'd7, 2'd0, 6'b000000, 1'b1, 1'b0, 1'b0},
    {3'd0, 3'd1, 2'd3, 6'b000010, 1'b0, 1'b0, 1'b1},
    {3'd0, 3'd1, 2'd3, 6'b000011, 1'b0, 1'b0, 1'b0},
    {3'd6, 3'd0, 2'd3, 6'b000001, 1'b0, 1'b0, 1'b1},
    {3'd7, 3'd6, 2'd2, 6'b000000, 1'b1, 1'b1, 1'b0},
    {3'd5, 3'd2, 2'd1, 6'b000000, 1'b0, 1'b0, 1'b0},
    {3'd5, 3'd2, 2'd1, 6'b100000, 1'b0, 1'b0, 1'b1},
    {3'd3, 3'd3, 2'd0, 6'b001000, 1'b0, 1'b0, 1'b1},
    {3'd1, 3'd6, 2'd3, 6'b000010, 1'b1, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter();
    flow_start = 1'b1;
    step();
    flow_start = 1'b0;
  endtask

  task automatic leave();
    bit seen = 1'b0;
    done_req = 1'b1;
    for (int k = 0; k < 600 && !seen; k++) begin
      step();
      seen = flow_exit;
    end
    done_req = 1'b0;
    chk(seen, "R10 exit reached", int'(seen), 1);
  endtask

  // counts strobe changes on pin b over n clocks and judges each xfer_pulse
  task automatic watch(input int b, input int n, output int togg,
                       output int first, output int pulses, output int badp);
    logic prev, cur, expp;
    togg = 0; first = 0; pulses = 0; badp = 0;
    prev = ctl_out[b];
    for (int k = 1; k <= n; k++) begin
      step();
      cur  = ctl_out[b];
      expp = (cur != prev) && ((cur && xfer_on_rise) || (!cur && xfer_on_fall));
      if (cur != prev) begin
        togg++;
        if (first == 0) first = k;
      end
      if (xfer_pulse !== expp) badp++;
      pulses += int'(xfer_pulse);
      prev = cur;
    end
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int t, f, p, bp;
    logic s0;
    logic [16:0] v;
    rst = 1'b1; flow_start = 1'b0; done_req = 1'b0; rdy_in = '0;
    fifo_flag = 1'b0; cpu_rdy = 1'b0; term_a_sel = 3'd7; term_b_sel = 3'd7;
    logic_fn = 2'd0; toggle_when = 1'b1; half_per = 8'd2;
    xfer_on_rise = 1'b1; xfer_on_fall = 1'b1; strb_sel = 3'd0;
    ctl_when0 = '0; ctl_when1 = '0; sustain_en = 1'b0; state_ctl = 6'h15;
    step(); step(); step();
    chk(ctl_out == 6'h00, "R1 reset ctl_out", int'(ctl_out), 0);
    chk(!xfer_pulse && !flow_exit, "R1 reset pulses", int'({xfer_pulse, flow_exit}), 0);
    rst = 1'b0;
    step();
    chk(ctl_out == 6'h15, "R1 idle follows state_ctl", int'(ctl_out), 'h15);

    // table walk: result seen on the non-strobe pins (R2 R3 R8)
    state_ctl = '0; ctl_when0 = 6'h00; ctl_when1 = 6'h3E;
    enter();
    for (int i = 0; i < 16; i++) begin
      v = VEC[i];
      term_a_sel = v[16:14]; term_b_sel = v[13:11]; logic_fn = v[10:9];
      rdy_in = v[8:3]; fifo_flag = v[2]; cpu_rdy = v[1];
      step();
      chk(ctl_out[5:1] == {5{v[0]}}, "R2 R3 R8 vector",
          int'(ctl_out[5:1]), int'({5{v[0]}}));
    end
    leave();

    // rates (R5)
    term_a_sel = 3'd7; term_b_sel = 3'd7; logic_fn = 2'd0; cpu_rdy = 1'b1;
    half_per = 8'd2; enter(); watch(0, 8, t, f, p, bp);
    chk(t == 8, "R5 half_per 2 toggles", t, 8); leave();
    half_per = 8'd0; enter(); watch(0, 8, t, f, p, bp);
    chk(t == 8, "R5 half_per 0 clamps", t, 8); leave();
    half_per = 8'd6; enter(); watch(0, 8, t, f, p, bp);
    chk(t == 2, "R5 half_per 6 toggles", t, 2);
    chk(f == 3, "R5 half_per 6 first edge", f, 3); leave();
    half_per = 8'd3; enter(); watch(0, 6, t, f, p, bp);
    chk(t == 4, "R5 half_per 3 toggles", t, 4); leave();

    // edge selection (R6)
    half_per = 8'd2; enter();
    xfer_on_rise = 1'b1; xfer_on_fall = 1'b0; watch(0, 8, t, f, p, bp);
    chk(p == 4 && bp == 0, "R6 rise only", p * 100 + bp, 400);
    xfer_on_rise = 1'b0; xfer_on_fall = 1'b1; watch(0, 8, t, f, p, bp);
    chk(p == 4 && bp == 0, "R6 fall only", p * 100 + bp, 400);
    xfer_on_rise = 1'b1; xfer_on_fall = 1'b1; watch(0, 8, t, f, p, bp);
    chk(p == 8 && bp == 0, "R6 both edges", p * 100 + bp, 800);
    xfer_on_rise = 1'b0; xfer_on_fall = 1'b0; watch(0, 4, t, f, p, bp);
    chk(p == 0 && t == 4, "R6 no edges enabled", p, 0);
    xfer_on_rise = 1'b1; xfer_on_fall = 1'b1;

    // polarity (R4)
    toggle_when = 1'b0; cpu_rdy = 1'b1; watch(0, 6, t, f, p, bp);
    chk(t == 0, "R4 freeze when result differs", t, 0);
    cpu_rdy = 1'b0; watch(0, 6, t, f, p, bp);
    chk(t == 6, "R4 toggle on result 0", t, 6);

    // not-ready (R7)
    toggle_when = 1'b1; cpu_rdy = 1'b1; watch(0, 3, t, f, p, bp);
    cpu_rdy = 1'b0; watch(0, 6, t, f, p, bp);
    chk(t <= 1 && p <= 1, "R7 edges after not-ready", t, 1);
    leave();

    // strobe pin choice (R9)
    strb_sel = 3'd3; ctl_when1 = 6'h3F; ctl_when0 = 6'h00; cpu_rdy = 1'b1;
    enter(); watch(3, 4, t, f, p, bp);
    chk(t == 4, "R9 strobe on pin 3", t, 4);
    chk((ctl_out & 6'h37) == 6'h37, "R9 pattern on other pins",
        int'(ctl_out & 6'h37), 'h37);
    leave();

    // done only on a boundary, no toggle there (R10)
    strb_sel = 3'd0; half_per = 8'd8; cpu_rdy = 1'b1;
    enter();
    s0 = ctl_out[0];
    done_req = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      chk(!flow_exit, "R10 no early exit", int'(flow_exit), 0);
    end
    step();
    chk(flow_exit, "R10 exit on boundary", int'(flow_exit), 1);
    chk(ctl_out[0] == s0, "R10 no toggle at exit", int'(ctl_out[0]), int'(s0));
    done_req = 1'b0;
    step();
    chk(!flow_exit, "R10 exit pulse one clock", int'(flow_exit), 0);

    // sustain (R11)
    half_per = 8'd2; strb_sel = 3'd2; state_ctl = 6'h04; cpu_rdy = 1'b0;
    sustain_en = 1'b1;
    step();
    enter(); state_ctl = 6'h00; leave();
    for (int k = 0; k < 3; k++) begin
      step();
      chk(ctl_out == 6'h04, "R11 level held", int'(ctl_out), 'h04);
    end
    state_ctl = 6'h04; step();
    chk(ctl_out == 6'h04, "R11 forced high", int'(ctl_out), 'h04);
    state_ctl = 6'h00; step();
    chk(ctl_out == 6'h00, "R11 released", int'(ctl_out), 0);

    // no sustain (R12)
    sustain_en = 1'b0; state_ctl = 6'h04; step();
    enter(); state_ctl = 6'h00; leave();
    step();
    chk(ctl_out == 6'h00, "R12 follows state_ctl", int'(ctl_out), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule